// File: doc/BRIEF.md
# Debug Address Breakpoint Unit

This block is the hardware breakpoint comparator of a small 16-bit microcontroller's debug engine. It stores four instruction-address breakpoints and one dual-purpose breakpoint. Every cycle it compares them with the instruction fetch address, the data-memory access address, or the destination register of the instruction being retired. When a qualified comparison succeeds, it issues a registered break request with a cause code. The debug state machine uses that request to take the core over.

Only a background-mode debug port can read or write the breakpoint registers. A select input sets the mode of the dual-purpose register. With the select low, that register matches data-memory addresses. With the select high, it matches a destination register, given as a module number and an index packed in its low bits. A monitor-enable input gates all comparisons. The unit also stays silent while the core is already in debug mode.

Top module: `dbg_brk_unit`

## Requirements
- R1: In reset and on the cycle after reset is released, all five breakpoint registers read back 0xFFFF, `brk_req` is 0 and `brk_cause` is 0.
- R2: A write takes effect only when `bg_mode` and `dbg_wr_en` are both 1. A write attempted while `bg_mode` is 0 leaves the register unchanged. `dbg_rdata` is 0 unless `bg_mode` and `dbg_rd_en` are both 1.
- R3: Register selects 0 to 3 are the instruction-address breakpoints and select 4 is the dual-purpose breakpoint. A write is visible on the same-cycle combinational read after the edge that stores it. Selects 5 to 7 ignore writes and read 0.
- R4: When `pc_valid` is 1 and `pc_addr` equals instruction breakpoint k, `brk_req` is 1 on the cycle after the next clock edge, with `brk_cause` = k (0 to 3).
- R5: While `mon_en` is 0, no match raises `brk_req`.
- R6: With `reg_brk_sel` = 0, `dmem_strobe` = 1 and `dmem_addr` equal to breakpoint 4 give cause 4. With the strobe at 0 there is no match.
- R7: With `reg_brk_sel` = 1, `wb_valid` = 1 and {`wb_module`, `wb_index`} equal to breakpoint 4 bits [8:0] (module in bits 8:5, index in bits 4:0) give cause 5. Bits 15:9 are ignored. In this mode the data address comparison is off. With the select at 0, the register comparison is off.
- R8: `brk_req` is registered. It is high for exactly the one cycle that follows each qualifying match cycle, and drops after a cycle with no qualifying match.
- R9: When several comparators match in one cycle, the lowest cause code wins. `brk_cause` is 0 whenever `brk_req` is 0.
- R10: While `in_debug` is 1, no match raises `brk_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bg_mode | input | 1 | Background debug access qualifier |
| dbg_wr_en | input | 1 | Register write strobe |
| dbg_rd_en | input | 1 | Register read strobe |
| dbg_addr | input | 3 | Register select |
| dbg_wdata | input | 16 | Write data |
| dbg_rdata | output | 16 | Read data (combinational) |
| mon_en | input | 1 | Debug monitor enable |
| reg_brk_sel | input | 1 | Breakpoint 4 mode: 0 data address, 1 register |
| in_debug | input | 1 | Core already in debug mode |
| pc_valid | input | 1 | Instruction fetch address valid |
| pc_addr | input | 16 | Instruction fetch address |
| dmem_strobe | input | 1 | Data-memory access valid |
| dmem_addr | input | 16 | Data-memory address |
| wb_valid | input | 1 | Instruction write-back valid |
| wb_module | input | 4 | Destination register module |
| wb_index | input | 5 | Destination register index |
| brk_req | output | 1 | Break request pulse |
| brk_cause | output | 3 | Breakpoint that fired |

## Verification
Read data is combinational. The bench checks it shortly after the falling edge on which the select is driven, and one cycle after the write edge. A break request shows up one rising edge after the cycle that carries the matching address. The bench drives each vector on a falling edge and samples `brk_req` and `brk_cause` 1 ns after the following rising edge, so each check sees only the vector just applied. Writes are never overlapped with comparison vectors, so the expected result always follows from the register contents that were settled before that vector.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  typedef enum logic {
    BP4_DATA_ADDR = 1'b0,
    BP4_DEST_REG  = 1'b1
  } bp4_mode_e;

  // number of causes: instruction breakpoints + data + register
  function automatic int cause_count(input int num_pc_bp);
    return num_pc_bp + 2;
  endfunction
endpackage

// File: rtl/dbg_brk_regfile.sv
module dbg_brk_regfile #(
  parameter int AW     = 16,
  parameter int NUM_BP = 5,
  parameter int SEL_W  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bg_mode,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [SEL_W-1:0]     sel,
  input  logic [AW-1:0]        wdata,
  output logic [AW-1:0]        rdata,
  output logic [NUM_BP*AW-1:0] bp_flat
);
  logic [AW-1:0]     bp_q [NUM_BP];
  logic [NUM_BP-1:0] wr_hit;
  logic              access_ok;

  // only the background debug path may touch the registers
  assign access_ok = bg_mode;

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    assign wr_hit[g] = access_ok && wr_en && (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bp_q[g] <= '1;
      else if (wr_hit[g]) bp_q[g] <= wdata;
    end

    assign bp_flat[g*AW +: AW] = bp_q[g];
  end

  always_comb begin
    rdata = '0;
    if (access_ok && rd_en) begin
      for (int i = 0; i < NUM_BP; i++) begin
        if (sel == SEL_W'(i)) rdata = bp_q[i];
      end
    end
  end
endmodule

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
  import dbg_brk_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NUM_PC_BP = 4,
  parameter int MOD_W     = 4,
  parameter int IDX_W     = 5,
  localparam int NUM_BP   = NUM_PC_BP + 1,
  localparam int NHIT     = NUM_PC_BP + 2,
  localparam int KEY_W    = MOD_W + IDX_W
) (
  input  logic [NUM_BP*AW-1:0] bp_flat,
  input  logic                 reg_brk_sel,
  input  logic                 pc_valid,
  input  logic [AW-1:0]        pc_addr,
  input  logic                 dmem_strobe,
  input  logic [AW-1:0]        dmem_addr,
  input  logic                 wb_valid,
  input  logic [MOD_W-1:0]     wb_module,
  input  logic [IDX_W-1:0]     wb_index,
  output logic [NHIT-1:0]      hit_vec
);
  // destination register key: module above index
  function automatic logic [KEY_W-1:0] dest_key(input logic [MOD_W-1:0] m,
                                                input logic [IDX_W-1:0] r);
    return {m, r};
  endfunction

  function automatic logic [KEY_W-1:0] stored_key(input logic [AW-1:0] bp);
    return bp[KEY_W-1:0];
  endfunction

  logic [AW-1:0] bp_dual;
  bp4_mode_e     mode;

  assign bp_dual = bp_flat[NUM_PC_BP*AW +: AW];
  assign mode    = bp4_mode_e'(reg_brk_sel);

  for (genvar g = 0; g < NUM_PC_BP; g++) begin : g_pc
    assign hit_vec[g] = pc_valid && (pc_addr == bp_flat[g*AW +: AW]);
  end

  assign hit_vec[NUM_PC_BP] = (mode == BP4_DATA_ADDR) && dmem_strobe &&
                              (dmem_addr == bp_dual);
  assign hit_vec[NUM_PC_BP+1] = (mode == BP4_DEST_REG) && wb_valid &&
                                (dest_key(wb_module, wb_index) == stored_key(bp_dual));
endmodule

// File: rtl/dbg_brk_arb.sv
module dbg_brk_arb #(
  parameter int NHIT    = 6,
  parameter int CAUSE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NHIT-1:0]    hit_vec,
  input  logic               mon_en,
  input  logic               in_debug,
  output logic               fire,
  output logic               brk_req,
  output logic [CAUSE_W-1:0] brk_cause
);
  // lowest-numbered set bit
  function automatic logic [CAUSE_W-1:0] first_hit(input logic [NHIT-1:0] v);
    logic [CAUSE_W-1:0] r;
    r = '0;
    for (int i = NHIT - 1; i >= 0; i--) begin
      if (v[i]) r = CAUSE_W'(i);
    end
    return r;
  endfunction

  assign fire = mon_en && !in_debug && (|hit_vec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_req   <= 1'b0;
      brk_cause <= '0;
    end else begin
      brk_req   <= fire;
      brk_cause <= fire ? first_hit(hit_vec) : '0;
    end
  end
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
  import dbg_brk_pkg::*;
#(
  parameter int AW        = 16,
  parameter int NUM_PC_BP = 4,
  parameter int MOD_W     = 4,
  parameter int IDX_W     = 5,
  localparam int NUM_BP   = NUM_PC_BP + 1,
  localparam int SEL_W    = $clog2(NUM_BP),
  localparam int NHIT     = NUM_PC_BP + 2,
  localparam int CAUSE_W  = $clog2(NUM_PC_BP + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bg_mode,
  input  logic               dbg_wr_en,
  input  logic               dbg_rd_en,
  input  logic [SEL_W-1:0]   dbg_addr,
  input  logic [AW-1:0]      dbg_wdata,
  output logic [AW-1:0]      dbg_rdata,
  input  logic               mon_en,
  input  logic               reg_brk_sel,
  input  logic               in_debug,
  input  logic               pc_valid,
  input  logic [AW-1:0]      pc_addr,
  input  logic               dmem_strobe,
  input  logic [AW-1:0]      dmem_addr,
  input  logic               wb_valid,
  input  logic [MOD_W-1:0]   wb_module,
  input  logic [IDX_W-1:0]   wb_index,
  output logic               brk_req,
  output logic [CAUSE_W-1:0] brk_cause
);
  logic [NUM_BP*AW-1:0] bp_flat;
  logic [NHIT-1:0]      hit_vec;
  logic                 fire;

  dbg_brk_regfile #(.AW(AW), .NUM_BP(NUM_BP), .SEL_W(SEL_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .bg_mode (bg_mode),
    .wr_en   (dbg_wr_en),
    .rd_en   (dbg_rd_en),
    .sel     (dbg_addr),
    .wdata   (dbg_wdata),
    .rdata   (dbg_rdata),
    .bp_flat (bp_flat)
  );

  dbg_brk_cmp #(.AW(AW), .NUM_PC_BP(NUM_PC_BP), .MOD_W(MOD_W), .IDX_W(IDX_W)) u_cmp (
    .bp_flat     (bp_flat),
    .reg_brk_sel (reg_brk_sel),
    .pc_valid    (pc_valid),
    .pc_addr     (pc_addr),
    .dmem_strobe (dmem_strobe),
    .dmem_addr   (dmem_addr),
    .wb_valid    (wb_valid),
    .wb_module   (wb_module),
    .wb_index    (wb_index),
    .hit_vec     (hit_vec)
  );

  dbg_brk_arb #(.NHIT(NHIT), .CAUSE_W(CAUSE_W)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .hit_vec   (hit_vec),
    .mon_en    (mon_en),
    .in_debug  (in_debug),
    .fire      (fire),
    .brk_req   (brk_req),
    .brk_cause (brk_cause)
  );
endmodule

// File: rtl/dbg_brk_unit_chk.sv
module dbg_brk_unit_chk #(
  parameter int AW      = 16,
  parameter int NUM_BP  = 5,
  parameter int NHIT    = 6,
  parameter int CAUSE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bg_mode,
  input logic               dbg_wr_en,
  input logic               mon_en,
  input logic               in_debug,
  input logic               reg_brk_sel,
  input logic               brk_req,
  input logic [CAUSE_W-1:0] brk_cause,
  input logic [NHIT-1:0]    hit_vec,
  input logic [NUM_BP*AW-1:0] bp_flat
);
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!bg_mode || !dbg_wr_en) |=> $stable(bp_flat)); // R2

  AST_HIT_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ((|hit_vec) && mon_en && !in_debug) |=> brk_req); // R4

  AST_MON_GATES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(mon_en)); // R5

  AST_REG_MODE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && $past(reg_brk_sel)) |-> (brk_cause != CAUSE_W'(NUM_BP - 1))); // R7

  AST_REQ_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(|hit_vec)); // R8

  AST_IDLE_CAUSE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !brk_req |-> (brk_cause == '0)); // R9

  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> (brk_cause < CAUSE_W'(NHIT))); // R9

  AST_DEBUG_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !$past(in_debug)); // R10
endmodule

bind dbg_brk_unit dbg_brk_unit_chk #(
  .AW(AW), .NUM_BP(NUM_BP), .NHIT(NHIT), .CAUSE_W(CAUSE_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bg_mode     (bg_mode),
  .dbg_wr_en   (dbg_wr_en),
  .mon_en      (mon_en),
  .in_debug    (in_debug),
  .reg_brk_sel (reg_brk_sel),
  .brk_req     (brk_req),
  .brk_cause   (brk_cause),
  .hit_vec     (hit_vec),
  .bp_flat     (bp_flat)
);

// File: tb/dbg_brk_unit_bench.sv
`timescale 1ns/1ps
module dbg_brk_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bg_mode = 0, dbg_wr_en = 0, dbg_rd_en = 0;
  logic [2:0]  dbg_addr = '0;
  logic [15:0] dbg_wdata = '0;
  logic [15:0] dbg_rdata;
  logic        mon_en = 0, reg_brk_sel = 0, in_debug = 0;
  logic        pc_valid = 0, dmem_strobe = 0, wb_valid = 0;
  logic [15:0] pc_addr = '0, dmem_addr = '0;
  logic [3:0]  wb_module = '0;
  logic [4:0]  wb_index = '0;
  logic        brk_req;
  logic [2:0]  brk_cause;

  int vectors = 0;
  int fails = 0;
  logic [15:0] model [5];
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  dbg_brk_unit u_dbg_brk_unit (
    .clk(clk), .rst_n(rst_n), .bg_mode(bg_mode), .dbg_wr_en(dbg_wr_en),
    .dbg_rd_en(dbg_rd_en), .dbg_addr(dbg_addr), .dbg_wdata(dbg_wdata),
    .dbg_rdata(dbg_rdata), .mon_en(mon_en), .reg_brk_sel(reg_brk_sel),
    .in_debug(in_debug), .pc_valid(pc_valid), .pc_addr(pc_addr),
    .dmem_strobe(dmem_strobe), .dmem_addr(dmem_addr), .wb_valid(wb_valid),
    .wb_module(wb_module), .wb_index(wb_index), .brk_req(brk_req),
    .brk_cause(brk_cause)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rnd();
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return seed;
  endfunction

  // expected {req, cause} from the bench's own register copy
  function automatic logic [3:0] expect_out();
    logic [5:0] m;
    m[0] = pc_valid && pc_addr == model[0];
    m[1] = pc_valid && pc_addr == model[1];
    m[2] = pc_valid && pc_addr == model[2];
    m[3] = pc_valid && pc_addr == model[3];
    m[4] = !reg_brk_sel && dmem_strobe && dmem_addr == model[4];
    m[5] = reg_brk_sel && wb_valid && (wb_module * 32 + wb_index) == (model[4] % 512);
    if (!mon_en || in_debug || m == 0) return 4'd0;
    for (int k = 0; k < 6; k++) if (m[k]) return {1'b1, 3'(k)};
    return 4'd0;
  endfunction

  task automatic quiet();
    bg_mode = 0; dbg_wr_en = 0; dbg_rd_en = 0;
    pc_valid = 0; dmem_strobe = 0; wb_valid = 0;
  endtask

  task automatic reg_write(input logic bg, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    quiet();
    bg_mode = bg; dbg_wr_en = 1; dbg_addr = a; dbg_wdata = d;
    if (bg && a < 5) model[a] = d;
    @(negedge clk);
    quiet();
  endtask

  task automatic reg_read(input logic bg, input logic [2:0] a, input logic [15:0] exp,
                          input string tag);
    @(negedge clk);
    quiet();
    bg_mode = bg; dbg_rd_en = 1; dbg_addr = a;
    #1;
    check(tag, dbg_rdata, exp);
  endtask

  // apply the current compare inputs for one cycle, check after the next rising edge
  task automatic apply(input string tag);
    logic [3:0] e;
    e = expect_out();
    @(posedge clk);
    #1;
    check(tag, {brk_req, brk_cause}, e);
    @(negedge clk);
  endtask

  task automatic set_cmp(input logic mon, input logic dbg, input logic rsel,
                         input logic pv, input logic [15:0] pa,
                         input logic ds, input logic [15:0] da,
                         input logic wv, input logic [3:0] wm, input logic [4:0] wi);
    quiet();
    mon_en = mon; in_debug = dbg; reg_brk_sel = rsel;
    pc_valid = pv; pc_addr = pa; dmem_strobe = ds; dmem_addr = da;
    wb_valid = wv; wb_module = wm; wb_index = wi;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 5; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    #1;
    check("R1 req in reset", {brk_req, brk_cause}, 4'd0);
    rst_n = 1;
    @(posedge clk); #1;
    check("R1 req after reset", {brk_req, brk_cause}, 4'd0);
    for (int i = 0; i < 5; i++) reg_read(1, 3'(i), 16'hFFFF, "R1 reset value");

    // all registers hold 0xFFFF: lowest wins
    @(negedge clk);
    set_cmp(1, 0, 0, 1, 16'hFFFF, 1, 16'hFFFF, 0, 0, 0);
    apply("R9 reset tie");
    set_cmp(1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply("R8 drop after hit");

    // R2: non-background accesses
    reg_write(0, 3'd1, 16'h1111);
    reg_read(1, 3'd1, 16'hFFFF, "R2 write ignored");
    reg_read(0, 3'd0, 16'h0000, "R2 read outside bg");
    reg_write(1, 3'd6, 16'h2222);
    reg_read(1, 3'd6, 16'h0000, "R3 empty select");
    reg_read(1, 3'd5, 16'h0000, "R3 empty select 5");

    reg_write(1, 3'd0, 16'h0100);
    reg_write(1, 3'd1, 16'h0200);
    reg_write(1, 3'd2, 16'h0300);
    reg_write(1, 3'd3, 16'h0200);
    reg_write(1, 3'd4, 16'h0A0A);
    for (int i = 0; i < 5; i++) reg_read(1, 3'(i), model[i], "R3 readback");

    @(negedge clk);
    set_cmp(1, 0, 0, 1, 16'h0300, 0, 0, 0, 0, 0); apply("R4 bp2");
    set_cmp(1, 0, 0, 1, 16'h0200, 0, 0, 0, 0, 0); apply("R9 bp1 over bp3");
    set_cmp(0, 0, 0, 1, 16'h0100, 0, 0, 0, 0, 0); apply("R5 mon off");
    set_cmp(1, 1, 0, 1, 16'h0100, 0, 0, 0, 0, 0); apply("R10 in debug");
    set_cmp(1, 0, 0, 0, 0, 1, 16'h0A0A, 0, 0, 0); apply("R6 data hit");
    set_cmp(1, 0, 0, 0, 0, 0, 16'h0A0A, 0, 0, 0); apply("R6 no strobe");
    set_cmp(1, 0, 1, 0, 0, 1, 16'h0A0A, 0, 0, 0); apply("R7 data off in reg mode");
    set_cmp(1, 0, 0, 1, 16'h0100, 1, 16'h0A0A, 0, 0, 0); apply("R9 pc over data");

    // R7: module 0xA, index 0x13, junk in bits 15:9
    reg_write(1, 3'd4, 16'hFF53);
    @(negedge clk);
    set_cmp(1, 0, 1, 0, 0, 0, 0, 1, 4'hA, 5'h13); apply("R7 reg hit");
    set_cmp(1, 0, 0, 0, 0, 0, 0, 1, 4'hA, 5'h13); apply("R7 reg off in data mode");
    set_cmp(1, 0, 1, 0, 0, 0, 0, 0, 4'hA, 5'h13); apply("R7 no wb valid");

    // exhaustive destination sweep in register mode
    for (int k = 0; k < 512; k++) begin
      set_cmp(1, 0, 1, 0, 0, 0, 0, 1, 4'(k / 32), 5'(k % 32));
      apply("R7 key sweep");
    end

    // exhaustive fetch-address sweep
    reg_write(1, 3'd3, 16'hC001);
    @(negedge clk);
    for (int a = 0; a < 65536; a++) begin
      set_cmp(1, 0, 0, 1, 16'(a), 0, 0, 0, 0, 0);
      apply("R4 address sweep");
    end

    // mixed random vectors near the stored values
    for (int n = 0; n < 6000; n++) begin
      logic [31:0] r;
      if (n % 500 == 0) begin
        for (int i = 0; i < 5; i++) reg_write(1, 3'(i), 16'(rnd() % 8));
        @(negedge clk);
      end
      r = rnd();
      set_cmp(r[0] | r[1], r[2] & r[3], r[4], r[5], 16'(r[15:13]),
              r[6], 16'(r[18:16]), r[7], 4'(r[20:19]), 5'(r[23:21] % 8));
      apply("R9 mixed sweep");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule